// File: doc/BRIEF.md
# Bridge Interrupt Status Aggregator

This block gathers interrupt requests from the local side of a bus bridge and presents them to the host as one interrupt. Up to sixteen request lines and a set of mailbox flags feed a single status word. An enable word chooses which status bits may raise the host interrupt. A control bit selects how that interrupt is delivered: either as a level on a legacy wire, or as a one-cycle request pulse that a downstream packet engine turns into a message.

The two kinds of status bit are cleared in different ways. A request-line bit mirrors its input, so it can only be cleared by the component that drives the line. A mailbox bit latches when it is posted, and the host clears it by writing a 1 to it in the status word. Mailbox flags can be posted from either side of the bridge: by a host write to the mailbox address, or by a strobe on the local side. The block does not rank the sources. Host software reads the status word and decides the order in which to service them.

Top module: `irq_aggregator`

## Requirements
- R1: `NUM_IRQ` (1 to 16) sets how many request lines there are. Line k appears at status bit k. `NUM_MBX` (1 to 16) sets how many mailbox flags there are. Mailbox flag j appears at status bit 16+j.
- R2: A line's status bit equals its input as sampled at the previous clock edge. Writing to the status word has no effect on line bits.
- R3: A mailbox flag j is set when either of two things happens: the host writes to byte offset 0x8 with data bit j equal to 1, or `mbx_post_i` is high with `mbx_data_i[j]` equal to 1. The flag then stays set.
- R4: A host write to status (offset 0x0) with data bit 16+j equal to 1 clears mailbox flag j. A 0 in that bit leaves the flag unchanged.
- R5: If a post and a clear reach the same mailbox flag in the same cycle, the flag is left set.
- R6: The enable word sits at offset 0x4 and uses the same bit layout as status. A status bit takes part in raising the interrupt only while its enable bit is 1.
- R7: Bit 0 of the control word at offset 0xC selects the delivery form: 0 means legacy wire, 1 means message pulse. In one form, the output of the other form stays low.
- R8: In wire form, `intx_o` is high one cycle after the enabled status becomes nonzero. It stays high for as long as the enabled status is nonzero.
- R9: In message form, a rise of the enabled status from zero to nonzero produces exactly one `msi_req_o` pulse, one cycle wide.
- R10: In message form, a status write that clears at least one set mailbox flag produces a new pulse if the enabled status is still nonzero after the clear.
- R11: Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`. Unused bits read as 0, and the mailbox offset reads as 0.
- R12: After reset, the following are all 0: the enable word, the mode bit, the mailbox flags, both interrupt outputs and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Local request lines, level-sensitive |
| mbx_post_i | input | 1 | Local-side mailbox post strobe |
| mbx_data_i | input | NUM_MBX | Flags to set with the post |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, registered |
| msi_req_o | output | 1 | One-cycle message interrupt request |
| intx_o | output | 1 | Legacy level interrupt |

## Verification
A host clear of a mailbox flag can land in the same cycle as a local-side post. The bench provokes this by driving a status write and the post strobe on the same clock edge. It does this twice: once with both aimed at the same flag, and once with each aimed at a different flag. It then judges the result by reading back the status word, which must keep the posted flag and drop only the cleared one that was not reposted. In message form, a clear can also fall while a request line is still held high. That case is judged by counting exactly one extra pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int REG_W   = 32;
   localparam int MBX_LSB = 16;
   localparam int MAX_SRC = 16;

   localparam logic [7:0] OFF_STATUS  = 8'h00;
   localparam logic [7:0] OFF_ENABLE  = 8'h04;
   localparam logic [7:0] OFF_MAILBOX = 8'h08;
   localparam logic [7:0] OFF_CONTROL = 8'h0C;

   typedef enum logic {
      MODE_WIRE = 1'b0,
      MODE_MSG  = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
   import irq_agg_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int NUM_MBX = 4,
   parameter int ADDR_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_i,
   input  logic                reg_rd_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [REG_W-1:0]    reg_wdata_i,
   input  logic [NUM_IRQ-1:0]  line_stat_i,
   input  logic [NUM_MBX-1:0]  mbx_stat_i,
   output logic [NUM_IRQ-1:0]  en_line_o,
   output logic [NUM_MBX-1:0]  en_mbx_o,
   output irq_mode_e           mode_o,
   output logic [NUM_MBX-1:0]  host_set_o,
   output logic [NUM_MBX-1:0]  clr_o,
   output logic [REG_W-1:0]    rdata_o
);
   localparam logic [ADDR_W-1:0] A_STAT = OFF_STATUS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_EN   = OFF_ENABLE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_MBX  = OFF_MAILBOX[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CTL  = OFF_CONTROL[ADDR_W-1:0];

   logic hit_stat, hit_en, hit_mbx, hit_ctl;
   logic [REG_W-1:0] rd_word, rdata_q;
   logic [NUM_IRQ-1:0] en_line_q;
   logic [NUM_MBX-1:0] en_mbx_q;
   irq_mode_e mode_q;
   logic unused_wdata;

   assign hit_stat = (reg_addr_i == A_STAT);
   assign hit_en   = (reg_addr_i == A_EN);
   assign hit_mbx  = (reg_addr_i == A_MBX);
   assign hit_ctl  = (reg_addr_i == A_CTL);
   assign unused_wdata = ^reg_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_line_q <= '0;
         en_mbx_q  <= '0;
         mode_q    <= MODE_WIRE;
      end else if (reg_wr_i) begin
         if (hit_en) begin
            en_line_q <= reg_wdata_i[NUM_IRQ-1:0];
            en_mbx_q  <= reg_wdata_i[MBX_LSB +: NUM_MBX];
         end
         if (hit_ctl) mode_q <= irq_mode_e'(reg_wdata_i[0]);
      end
   end

   assign host_set_o = (reg_wr_i && hit_mbx)  ? reg_wdata_i[NUM_MBX-1:0]       : '0;
   assign clr_o      = (reg_wr_i && hit_stat) ? reg_wdata_i[MBX_LSB +: NUM_MBX] : '0;

   always_comb begin
      rd_word = '0;
      if (hit_stat) begin
         rd_word[NUM_IRQ-1:0]        = line_stat_i;
         rd_word[MBX_LSB +: NUM_MBX] = mbx_stat_i;
      end else if (hit_en) begin
         rd_word[NUM_IRQ-1:0]        = en_line_q;
         rd_word[MBX_LSB +: NUM_MBX] = en_mbx_q;
      end else if (hit_ctl) begin
         rd_word[0] = mode_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (reg_rd_i) rdata_q <= rd_word;
   end

   assign en_line_o = en_line_q;
   assign en_mbx_o  = en_mbx_q;
   assign mode_o    = mode_q;
   assign rdata_o   = rdata_q;

   AST_MBX_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R11
      (reg_rd_i && hit_mbx) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
   parameter int NUM_IRQ = 16,
   parameter int NUM_MBX = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic [NUM_MBX-1:0] set_i,
   input  logic [NUM_MBX-1:0] clr_i,
   output logic [NUM_IRQ-1:0] line_o,
   output logic [NUM_MBX-1:0] mbx_o,
   output logic               rearm_o
);
   logic [NUM_IRQ-1:0] line_q;
   logic rearm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= irq_i;
   end

   for (genvar j = 0; j < NUM_MBX; j++) begin : g_mbx
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (set_i[j]) flag_q <= 1'b1;
         else if (clr_i[j]) flag_q <= 1'b0;
      end
      assign mbx_o[j] = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rearm_q <= 1'b0;
      else        rearm_q <= |(clr_i & mbx_o & ~set_i);
   end

   assign line_o  = line_q;
   assign rearm_o = rearm_q;

   AST_LINE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) // R2
      1'b1 |=> (line_o == $past(irq_i)));
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R5
      (|set_i) |=> ((mbx_o & $past(set_i)) == $past(set_i)));
   AST_CLEAR_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) // R4
      (set_i == '0) |=> ((mbx_o & ~$past(mbx_o)) == '0));
endmodule

// File: rtl/irq_agg_signal.sv
module irq_agg_signal
   import irq_agg_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int NUM_MBX = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  irq_mode_e          mode_i,
   input  logic [NUM_IRQ-1:0] line_i,
   input  logic [NUM_MBX-1:0] mbx_i,
   input  logic [NUM_IRQ-1:0] en_line_i,
   input  logic [NUM_MBX-1:0] en_mbx_i,
   input  logic               rearm_i,
   output logic               intx_o,
   output logic               msi_o
);
   logic pend, pend_q, intx_q, msi_q;

   assign pend = (|(line_i & en_line_i)) || (|(mbx_i & en_mbx_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         intx_q <= 1'b0;
         msi_q  <= 1'b0;
      end else begin
         pend_q <= pend;
         intx_q <= (mode_i == MODE_WIRE) && pend;
         msi_q  <= (mode_i == MODE_MSG) && pend && (!pend_q || rearm_i);
      end
   end

   assign intx_o = intx_q;
   assign msi_o  = msi_q;

   AST_WIRE_QUIET_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n) // R7
      (mode_i == MODE_MSG) |=> !intx_o);
   AST_MSG_QUIET_IN_WIRE: assert property (@(posedge clk) disable iff (!rst_n) // R7
      (mode_i == MODE_WIRE) |=> !msi_o);
   AST_WIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) // R8
      ((mode_i == MODE_WIRE) && (|(line_i & en_line_i))) |=> intx_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int NUM_MBX = 4,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               mbx_post_i,
   input  logic [NUM_MBX-1:0] mbx_data_i,
   input  logic               reg_wr_i,
   input  logic               reg_rd_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               msi_req_o,
   output logic               intx_o
);
   if (NUM_IRQ < 1 || NUM_IRQ > MAX_SRC) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..16");
   end
   if (NUM_MBX < 1 || NUM_MBX > MAX_SRC) begin : g_bad_mbx
      $error("NUM_MBX must lie in 1..16");
   end
   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 4..8");
   end

   logic [NUM_IRQ-1:0] line_stat, en_line;
   logic [NUM_MBX-1:0] mbx_stat, en_mbx, host_set, clr, set_all;
   logic rearm;
   irq_mode_e mode;

   assign set_all = host_set | (mbx_post_i ? mbx_data_i : '0);

   irq_agg_regs #(.NUM_IRQ(NUM_IRQ), .NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i),
      .line_stat_i(line_stat), .mbx_stat_i(mbx_stat),
      .en_line_o(en_line), .en_mbx_o(en_mbx), .mode_o(mode),
      .host_set_o(host_set), .clr_o(clr), .rdata_o(reg_rdata_o)
   );

   irq_agg_status #(.NUM_IRQ(NUM_IRQ), .NUM_MBX(NUM_MBX)) u_status (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
      .set_i(set_all), .clr_i(clr),
      .line_o(line_stat), .mbx_o(mbx_stat), .rearm_o(rearm)
   );

   irq_agg_signal #(.NUM_IRQ(NUM_IRQ), .NUM_MBX(NUM_MBX)) u_signal (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .line_i(line_stat), .mbx_i(mbx_stat),
      .en_line_i(en_line), .en_mbx_i(en_mbx), .rearm_i(rearm),
      .intx_o(intx_o), .msi_o(msi_req_o)
   );

   AST_MSI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) // R9
      msi_req_o |-> $past((|(line_stat & en_line)) || (|(mbx_stat & en_mbx))));
   AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n) // R6
      ((en_line == '0) && (en_mbx == '0)) |=> (!intx_o && !msi_req_o));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] irq_i = '0;
   logic mbx_post_i = 1'b0;
   logic [3:0] mbx_data_i = '0;
   logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
   logic [3:0] reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic msi_req_o, intx_o;

   int errors = 0, checks = 0, msi_cnt = 0, wide_err = 0;
   logic msi_prev = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_aggregator i_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
      .mbx_post_i(mbx_post_i), .mbx_data_i(mbx_data_i),
      .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .msi_req_o(msi_req_o), .intx_o(intx_o)
   );

   always @(negedge clk) begin
      if (rst_n && msi_req_o) begin
         msi_cnt++;
         if (msi_prev) wide_err++;
      end
      msi_prev = msi_req_o;
   end

   // {irq[15:0], enable[15:0], expected intx}
   localparam logic [32:0] VEC [0:5] = '{
      {16'h0001, 16'h0000, 1'b0},
      {16'h0001, 16'h0001, 1'b1},
      {16'h8000, 16'h0001, 1'b0},
      {16'h8000, 16'h8000, 1'b1},
      {16'h0000, 16'hFFFF, 1'b0},
      {16'h0A0A, 16'h0002, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_i = 1'b1; reg_addr_i = a;
      @(negedge clk);
      reg_rd_i = 1'b0;
      d = reg_rdata_o;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int base;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R12 reset state
      check("R12 intx", {31'd0, intx_o}, 32'd0);
      check("R12 rdata", reg_rdata_o, 32'd0);
      rd(4'h0, d); check("R12 status", d, 32'd0);
      rd(4'h4, d); check("R12 enable", d, 32'd0);
      rd(4'hC, d); check("R12 control", d, 32'd0);

      // Table: R1 R2 R6 R8 in wire form
      for (int i = 0; i < 6; i++) begin
         wr(4'h4, {16'h0, VEC[i][16:1]});
         @(negedge clk); irq_i = VEC[i][32:17];
         cycles(3);
         check("R8/R6 intx", {31'd0, intx_o}, {31'd0, VEC[i][0]});
         rd(4'h0, d); check("R1/R2 status", d, {16'h0, VEC[i][32:17]});
      end
      check("R7 no pulse in wire form", msi_cnt, 0);

      // R2: status writes do not touch line bits
      wr(4'h4, 32'h0);
      @(negedge clk); irq_i = 16'h0004;
      cycles(2);
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R2 line bit survives write", d, 32'h0000_0004);
      @(negedge clk); irq_i = 16'h0;
      cycles(2);
      rd(4'h0, d); check("R2 line bit follows source", d, 32'h0);

      // R3 host mailbox, R11 mailbox reads 0
      wr(4'h8, 32'h0000_0005);
      rd(4'h0, d); check("R3 host post", d, 32'h0005_0000);
      rd(4'h8, d); check("R11 mailbox reads 0", d, 32'h0);
      // R3 local post
      @(negedge clk); mbx_post_i = 1'b1; mbx_data_i = 4'h2;
      @(negedge clk); mbx_post_i = 1'b0; mbx_data_i = 4'h0;
      rd(4'h0, d); check("R3 local post", d, 32'h0007_0000);
      // R4 write-1-to-clear
      wr(4'h0, 32'h0001_0000);
      rd(4'h0, d); check("R4 clear one flag", d, 32'h0006_0000);
      wr(4'h0, 32'h0);
      rd(4'h0, d); check("R4 zero leaves flags", d, 32'h0006_0000);

      // R5 collisions
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = 32'h0002_0000;
      mbx_post_i = 1'b1; mbx_data_i = 4'h2;
      @(negedge clk);
      reg_wr_i = 1'b0; mbx_post_i = 1'b0; mbx_data_i = 4'h0;
      rd(4'h0, d); check("R5 post beats clear", d, 32'h0006_0000);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = 32'h0004_0000;
      mbx_post_i = 1'b1; mbx_data_i = 4'h2;
      @(negedge clk);
      reg_wr_i = 1'b0; mbx_post_i = 1'b0; mbx_data_i = 4'h0;
      rd(4'h0, d); check("R5 other flag cleared", d, 32'h0002_0000);

      // R11 unused bits and control width
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, d); check("R11 enable unused bits", d, 32'h000F_FFFF);
      wr(4'h4, 32'h0);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, d); check("R11 control unused bits", d, 32'h1);

      // Message form: R9 R10 R7
      wr(4'h0, 32'h000F_0000);
      rd(4'h0, d); check("R4 clear all", d, 32'h0);
      base = msi_cnt;
      wr(4'h4, 32'h0003_0001);
      @(negedge clk); irq_i = 16'h0001;
      cycles(4);
      check("R9 one pulse on rise", msi_cnt - base, 1);
      check("R7 wire low in message form", {31'd0, intx_o}, 32'd0);
      cycles(5);
      check("R9 no pulse while held", msi_cnt - base, 1);
      @(negedge clk); mbx_post_i = 1'b1; mbx_data_i = 4'h1;
      @(negedge clk); mbx_post_i = 1'b0; mbx_data_i = 4'h0;
      cycles(3);
      check("R9 no pulse when already pending", msi_cnt - base, 1);
      wr(4'h0, 32'h0001_0000);
      cycles(3);
      check("R10 re-pulse after clear", msi_cnt - base, 2);
      @(negedge clk); irq_i = 16'h0;
      cycles(3);
      wr(4'h8, 32'h0000_0002);
      cycles(3);
      check("R9 pulse on new rise", msi_cnt - base, 3);
      wr(4'h0, 32'h0002_0000);
      cycles(3);
      check("R10 no pulse when nothing left", msi_cnt - base, 3);
      check("R9 pulse width one cycle", wide_err, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule